// File: doc/BRIEF.md
# Multiply-Accumulate Register Peripheral

This block is an arithmetic peripheral that sits on a simple word-wide register bus. Software picks a 16x16 operation by choosing which address it writes the first operand to. The four choices are unsigned multiply, signed multiply, unsigned multiply-accumulate and signed multiply-accumulate. Writing the second operand performs the operation. The 32-bit result is read back as two words, and an extension word reports the sign, or the carry of the accumulation.

A second register group multiplies two 32-bit operands into a 64-bit result. Each operand is assembled from separate half-word writes, and the write of the upper half of the second operand starts the multiply. The whole register window answers at two base addresses, and both windows reach the same storage. Accesses are word accesses with per-byte write enables, and the byte address's bit 0 is ignored.

Top module: `mac_periph`

## Requirements
- R1: The register window covers byte offsets 0x00 to 0x2B above each of two bases, 0x130 and 0x4C0. A write through one base is visible through the other at the same offset.
- R2: A write of the first 16-bit operand selects the mode by its offset. Offset 0x00 selects unsigned multiply, 0x02 signed multiply, 0x04 unsigned accumulate and 0x06 signed accumulate. The operand reads back at any of these four offsets.
- R3: A write of the second operand at offset 0x08 runs the operation in the stored mode. The 32-bit result reads back at offset 0x0A (bits 15:0) and 0x0C (bits 31:16) in the very next bus cycle. The plain multiply modes overwrite the previous result.
- R4: The accumulate modes add the new product to the existing 32-bit result, wrapping modulo 2^32.
- R5: The extension word at offset 0x0E takes one of three values:
  - 0x0000 after an unsigned multiply.
  - 0xFFFF or 0x0000 after a signed multiply, according to whether the product is negative. After a signed accumulate, the same code follows bit 31 of the sum.
  - 0x0001 or 0x0000 after an unsigned accumulate, according to whether the 32-bit addition carried out.
- R6: A write at offset 0x0A loads the low result word and leaves the high word and the extension word unchanged. Writes at offsets 0x0C and 0x0E are ignored.
- R7: A write at offset 0x10 loads the low half of the wide first operand, clears its upper half and selects unsigned wide mode. Offset 0x14 does the same and selects signed wide mode. Offsets 0x12 and 0x16 replace only the upper half and keep the mode. All of these read back.
- R8: A write at offset 0x20 loads the low half of the wide second operand and clears its upper half. A write at 0x22 replaces the upper half and starts the 32x32 multiply, signed or unsigned per the wide mode. The next cycle, the 64-bit product reads back at 0x24, 0x26, 0x28 and 0x2A, as bits 15:0, 31:16, 47:32 and 63:48.
- R9: A read returns zero in three cases: an unmapped offset inside a window (0x18 to 0x1E, the gaps), any address outside both windows, and a cycle with no read. Writes to such addresses change nothing.
- R10: bus_be[0] enables bits 7:0 and bus_be[1] enables bits 15:8. Only the enabled bytes of the addressed register change, and a triggering write uses the merged value. A write with no byte enabled has no effect at all.
- R11: After reset every register reads zero, and the modes are unsigned multiply and unsigned wide.
- R12: Reads have no side effects: two consecutive reads of one address with no write between return the same value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Bus access valid this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address |
| bus_be | input | 2 | Byte write enables |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, combinational from the address |

## Verification
The hardest conditions to reach are the accumulator-boundary cases: the carry out of an unsigned accumulate, and a signed sum that crosses bit 31. The accumulator is reachable only through products and a low-word preset. The vector table therefore chains results, using two maximal unsigned products in a row to force the carry, and then signed steps that cross zero and come back. The wide signed top word is reached by assembling operands with their top bits set from half-word writes. A further test writes only the upper half, to show that the mode is kept.

// File: rtl/mac_pkg.sv
package mac_pkg;

   localparam int unsigned WORD_W    = 16;
   localparam int unsigned OFF_W     = 6;
   localparam int unsigned WIN_BYTES = 'h2C;

   // operand-1 offset bits [2:1] encode the mode in this order
   typedef enum logic [1:0] {
      NM_UMUL = 2'd0,
      NM_SMUL = 2'd1,
      NM_UMAC = 2'd2,
      NM_SMAC = 2'd3
   } nmode_e;

   localparam logic [OFF_W-1:0] O_A_UMUL = 6'h00;
   localparam logic [OFF_W-1:0] O_A_SMUL = 6'h02;
   localparam logic [OFF_W-1:0] O_A_UMAC = 6'h04;
   localparam logic [OFF_W-1:0] O_A_SMAC = 6'h06;
   localparam logic [OFF_W-1:0] O_B_GO   = 6'h08;
   localparam logic [OFF_W-1:0] O_R_LO   = 6'h0A;
   localparam logic [OFF_W-1:0] O_R_HI   = 6'h0C;
   localparam logic [OFF_W-1:0] O_XWORD  = 6'h0E;
   localparam logic [OFF_W-1:0] O_WA_LU  = 6'h10;
   localparam logic [OFF_W-1:0] O_WA_H0  = 6'h12;
   localparam logic [OFF_W-1:0] O_WA_LS  = 6'h14;
   localparam logic [OFF_W-1:0] O_WA_H1  = 6'h16;
   localparam logic [OFF_W-1:0] O_WB_L   = 6'h20;
   localparam logic [OFF_W-1:0] O_WB_HGO = 6'h22;
   localparam logic [OFF_W-1:0] O_WR_0   = 6'h24;
   localparam logic [OFF_W-1:0] O_WR_1   = 6'h26;
   localparam logic [OFF_W-1:0] O_WR_2   = 6'h28;
   localparam logic [OFF_W-1:0] O_WR_3   = 6'h2A;

   function automatic logic [WORD_W-1:0] merge16(input logic [WORD_W-1:0] old_v,
                                                 input logic [WORD_W-1:0] new_v,
                                                 input logic [1:0]        be);
      merge16 = {be[1] ? new_v[15:8] : old_v[15:8],
                 be[0] ? new_v[7:0]  : old_v[7:0]};
   endfunction

endpackage

// File: rtl/mac_win_dec.sv
module mac_win_dec
   import mac_pkg::*;
#(
   parameter int unsigned ADDR_W = 16,
   parameter int unsigned BASE_A = 'h130,
   parameter int unsigned BASE_B = 'h4C0
) (
   input  logic [ADDR_W-1:0] addr,
   output logic              hit,
   output logic [OFF_W-1:0]  off
);

   localparam int unsigned NWIN = 2;
   localparam int unsigned BASES [NWIN] = '{BASE_A, BASE_B};

   logic [NWIN-1:0]  win_hit;
   logic [OFF_W-1:0] win_off [NWIN];
   logic [ADDR_W:0]  a_ext;

   assign a_ext = {1'b0, addr};

   for (genvar i = 0; i < NWIN; i++) begin : g_win
      localparam logic [ADDR_W:0] LO = (ADDR_W+1)'(BASES[i]);
      localparam logic [ADDR_W:0] HI = (ADDR_W+1)'(BASES[i] + WIN_BYTES);
      assign win_hit[i] = (a_ext >= LO) && (a_ext < HI);
      assign win_off[i] = OFF_W'(a_ext - LO) & 6'h3E;
   end

   always_comb begin
      hit = |win_hit;
      off = '0;
      for (int i = 0; i < NWIN; i++) begin
         if (win_hit[i]) off = win_off[i];
      end
   end

endmodule

// File: rtl/mac_narrow.sv
module mac_narrow
   import mac_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [OFF_W-1:0]  off,
   input  logic [WORD_W-1:0] wdata,
   input  logic [1:0]        be,
   output logic [WORD_W-1:0] rd_data
);

   nmode_e            mode_q;
   logic [WORD_W-1:0] op1_q, op2_q, lo_q, hi_q, ext_q;
   logic [WORD_W-1:0] op1_m, op2_m, lo_m;
   logic [31:0]       prod_u, prod_s, acc, sum_s, res_nx;
   logic [32:0]       sum_u;
   logic [WORD_W-1:0] ext_nx;

   assign op1_m = merge16(op1_q, wdata, be);
   assign op2_m = merge16(op2_q, wdata, be);
   assign lo_m  = merge16(lo_q,  wdata, be);

   always_comb begin
      prod_u = {16'h0, op1_q} * {16'h0, op2_m};
      prod_s = {{16{op1_q[15]}}, op1_q} * {{16{op2_m[15]}}, op2_m};
      acc    = {hi_q, lo_q};
      sum_u  = {1'b0, acc} + {1'b0, prod_u};
      sum_s  = acc + prod_s;
      case (mode_q)
         NM_SMUL: begin
            res_nx = prod_s;
            ext_nx = {WORD_W{prod_s[31]}};
         end
         NM_UMAC: begin
            res_nx = sum_u[31:0];
            ext_nx = {{(WORD_W-1){1'b0}}, sum_u[32]};
         end
         NM_SMAC: begin
            res_nx = sum_s;
            ext_nx = {WORD_W{sum_s[31]}};
         end
         default: begin
            res_nx = prod_u;
            ext_nx = '0;
         end
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q <= NM_UMUL;
         op1_q  <= '0;
         op2_q  <= '0;
         lo_q   <= '0;
         hi_q   <= '0;
         ext_q  <= '0;
      end else if (wr_en) begin
         case (off)
            O_A_UMUL, O_A_SMUL, O_A_UMAC, O_A_SMAC: begin
               op1_q  <= op1_m;
               mode_q <= nmode_e'(off[2:1]);
            end
            O_B_GO: begin
               op2_q        <= op2_m;
               {hi_q, lo_q} <= res_nx;
               ext_q        <= ext_nx;
            end
            O_R_LO:  lo_q <= lo_m;
            default: ;
         endcase
      end
   end

   always_comb begin
      case (off)
         O_A_UMUL, O_A_SMUL, O_A_UMAC, O_A_SMAC: rd_data = op1_q;
         O_B_GO:  rd_data = op2_q;
         O_R_LO:  rd_data = lo_q;
         O_R_HI:  rd_data = hi_q;
         O_XWORD: rd_data = ext_q;
         default: rd_data = '0;
      endcase
   end

endmodule

// File: rtl/mac_wide.sv
module mac_wide
   import mac_pkg::*;
#(
   parameter bit SPLIT_PP = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [OFF_W-1:0]  off,
   input  logic [WORD_W-1:0] wdata,
   input  logic [1:0]        be,
   output logic [WORD_W-1:0] rd_data
);

   localparam int unsigned OPW = 2 * WORD_W;
   localparam int unsigned RW  = 2 * OPW;

   logic [OPW-1:0]    a_q, b_q, b_full;
   logic              sgn_q;
   logic [RW-1:0]     res_q, uprod, sprod;
   logic [WORD_W-1:0] a_lo_m, a_hi_m, b_lo_m, b_hi_m;

   assign a_lo_m = merge16(a_q[15:0],  wdata, be);
   assign a_hi_m = merge16(a_q[31:16], wdata, be);
   assign b_lo_m = merge16(b_q[15:0],  wdata, be);
   assign b_hi_m = merge16(b_q[31:16], wdata, be);
   assign b_full = {b_hi_m, b_q[15:0]};

   if (SPLIT_PP) begin : g_pp
      logic [OPW-1:0] p00, p01, p10, p11;
      assign p00   = {16'h0, a_q[15:0]}  * {16'h0, b_full[15:0]};
      assign p01   = {16'h0, a_q[15:0]}  * {16'h0, b_full[31:16]};
      assign p10   = {16'h0, a_q[31:16]} * {16'h0, b_full[15:0]};
      assign p11   = {16'h0, a_q[31:16]} * {16'h0, b_full[31:16]};
      assign uprod = {32'h0, p00} + {16'h0, p01, 16'h0}
                   + {16'h0, p10, 16'h0} + {p11, 32'h0};
   end else begin : g_flat
      assign uprod = {32'h0, a_q} * {32'h0, b_full};
   end

   // two's-complement correction of the unsigned product
   assign sprod = uprod - (a_q[31]    ? {b_full, 32'h0} : 64'h0)
                        - (b_full[31] ? {a_q,    32'h0} : 64'h0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         a_q   <= '0;
         b_q   <= '0;
         sgn_q <= 1'b0;
         res_q <= '0;
      end else if (wr_en) begin
         case (off)
            O_WA_LU: begin
               a_q   <= {16'h0, a_lo_m};
               sgn_q <= 1'b0;
            end
            O_WA_LS: begin
               a_q   <= {16'h0, a_lo_m};
               sgn_q <= 1'b1;
            end
            O_WA_H0, O_WA_H1: a_q[31:16] <= a_hi_m;
            O_WB_L:           b_q <= {16'h0, b_lo_m};
            O_WB_HGO: begin
               b_q   <= b_full;
               res_q <= sgn_q ? sprod : uprod;
            end
            default: ;
         endcase
      end
   end

   always_comb begin
      case (off)
         O_WA_LU, O_WA_LS: rd_data = a_q[15:0];
         O_WA_H0, O_WA_H1: rd_data = a_q[31:16];
         O_WB_L:           rd_data = b_q[15:0];
         O_WB_HGO:         rd_data = b_q[31:16];
         O_WR_0:           rd_data = res_q[15:0];
         O_WR_1:           rd_data = res_q[31:16];
         O_WR_2:           rd_data = res_q[47:32];
         O_WR_3:           rd_data = res_q[63:48];
         default:          rd_data = '0;
      endcase
   end

endmodule

// File: rtl/mac_periph.sv
module mac_periph
   import mac_pkg::*;
#(
   parameter int unsigned ADDR_W   = 16,
   parameter int unsigned BASE_A   = 'h130,
   parameter int unsigned BASE_B   = 'h4C0,
   parameter bit          WIDE_EN  = 1'b1,
   parameter bit          SPLIT_PP = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_sel,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [1:0]        bus_be,
   input  logic [WORD_W-1:0] bus_wdata,
   output logic [WORD_W-1:0] bus_rdata
);

   localparam longint unsigned SPACE = longint'(1) << ADDR_W;

   if (ADDR_W < 8 || ADDR_W > 32) begin : g_bad_aw
      $error("mac_periph: ADDR_W must lie in 8..32");
   end
   if ((BASE_A % 2) != 0 || (BASE_B % 2) != 0) begin : g_bad_align
      $error("mac_periph: bases must be word aligned");
   end
   if (longint'(BASE_A) + WIN_BYTES > SPACE || longint'(BASE_B) + WIN_BYTES > SPACE) begin : g_bad_range
      $error("mac_periph: a window exceeds the address space");
   end
   if (!((BASE_A + WIN_BYTES <= BASE_B) || (BASE_B + WIN_BYTES <= BASE_A))) begin : g_bad_ovl
      $error("mac_periph: windows overlap");
   end

   logic              hit, wr_en;
   logic [OFF_W-1:0]  off;
   logic [WORD_W-1:0] n_rd, w_rd;

   mac_win_dec #(
      .ADDR_W (ADDR_W),
      .BASE_A (BASE_A),
      .BASE_B (BASE_B)
   ) u_dec (
      .addr (bus_addr),
      .hit  (hit),
      .off  (off)
   );

   assign wr_en = bus_sel && bus_wr && hit && (|bus_be);

   mac_narrow u_narrow (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .off     (off),
      .wdata   (bus_wdata),
      .be      (bus_be),
      .rd_data (n_rd)
   );

   if (WIDE_EN) begin : g_wide
      mac_wide #(
         .SPLIT_PP (SPLIT_PP)
      ) u_wide (
         .clk     (clk),
         .rst_n   (rst_n),
         .wr_en   (wr_en),
         .off     (off),
         .wdata   (bus_wdata),
         .be      (bus_be),
         .rd_data (w_rd)
      );
   end else begin : g_nowide
      assign w_rd = '0;
   end

   // each engine returns zero for offsets it does not own
   assign bus_rdata = (bus_sel && !bus_wr && hit) ? (n_rd | w_rd) : '0;

endmodule

// File: rtl/mac_periph_chk.sv
module mac_periph_chk #(
   parameter int unsigned ADDR_W = 16,
   parameter int unsigned BASE_A = 'h130,
   parameter int unsigned BASE_B = 'h4C0
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bus_sel,
   input logic              bus_wr,
   input logic [ADDR_W-1:0] bus_addr,
   input logic [1:0]        bus_be,
   input logic [15:0]       bus_wdata,
   input logic [15:0]       bus_rdata
);

   logic [ADDR_W:0] a_ext;
   logic            in_a, in_b, in_win, is_rd;
   logic [5:0]      rel;

   assign a_ext  = {1'b0, bus_addr};
   assign in_a   = (a_ext >= (ADDR_W+1)'(BASE_A)) && (a_ext < (ADDR_W+1)'(BASE_A + 'h2C));
   assign in_b   = (a_ext >= (ADDR_W+1)'(BASE_B)) && (a_ext < (ADDR_W+1)'(BASE_B + 'h2C));
   assign in_win = in_a || in_b;
   assign rel    = (in_a ? 6'(a_ext - (ADDR_W+1)'(BASE_A)) : 6'(a_ext - (ADDR_W+1)'(BASE_B))) & 6'h3E;
   assign is_rd  = bus_sel && !bus_wr;

   p_idle_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !is_rd |-> (bus_rdata == 16'h0000));

   p_outside_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (is_rd && !in_win) |-> (bus_rdata == 16'h0000));

   p_gap_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (is_rd && in_win && rel >= 6'h18 && rel <= 6'h1E) |-> (bus_rdata == 16'h0000));

   p_ext_code_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (is_rd && in_win && rel == 6'h0E) |->
         (bus_rdata == 16'h0000 || bus_rdata == 16'h0001 || bus_rdata == 16'hFFFF));

   p_preset_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_sel && bus_wr && in_win && rel == 6'h0A && bus_be == 2'b11) |=>
         (!(is_rd && in_win && rel == 6'h0A) || bus_rdata == $past(bus_wdata)));

   p_read_stable_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (is_rd && $past(is_rd) && bus_addr == $past(bus_addr)) |-> $stable(bus_rdata));

endmodule

bind mac_periph mac_periph_chk #(
   .ADDR_W (ADDR_W),
   .BASE_A (BASE_A),
   .BASE_B (BASE_B)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_sel   (bus_sel),
   .bus_wr    (bus_wr),
   .bus_addr  (bus_addr),
   .bus_be    (bus_be),
   .bus_wdata (bus_wdata),
   .bus_rdata (bus_rdata)
);

// File: tb/mac_periph_tb.sv
module mac_periph_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_sel = 1'b0;
   logic        bus_wr = 1'b0;
   logic [15:0] bus_addr = '0;
   logic [1:0]  bus_be = 2'b11;
   logic [15:0] bus_wdata = '0;
   logic [15:0] bus_rdata;

   int n_chk = 0;
   int n_err = 0;

   localparam logic [15:0] BA = 16'h0130;
   localparam logic [15:0] BB = 16'h04C0;

   always #5 clk = ~clk;

   mac_periph u_dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_sel   (bus_sel),
      .bus_wr    (bus_wr),
      .bus_addr  (bus_addr),
      .bus_be    (bus_be),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata)
   );

   // {op1 offset, op1, op2, expected 32-bit result, expected extension}
   localparam int NVEC = 11;
   localparam logic [87:0] VEC [NVEC] = '{
      {8'h00, 16'h1234, 16'h5678, 32'h06260060, 16'h0000},
      {8'h00, 16'hFFFF, 16'hFFFF, 32'hFFFE0001, 16'h0000},
      {8'h02, 16'hFFFF, 16'h0002, 32'hFFFFFFFE, 16'hFFFF},
      {8'h02, 16'h8000, 16'h8000, 32'h40000000, 16'h0000},
      {8'h02, 16'hFFFF, 16'h0000, 32'h00000000, 16'h0000},
      {8'h04, 16'hFFFF, 16'hFFFF, 32'hFFFE0001, 16'h0000},
      {8'h04, 16'hFFFF, 16'hFFFF, 32'hFFFC0002, 16'h0001},
      {8'h04, 16'h0001, 16'h0001, 32'hFFFC0003, 16'h0000},
      {8'h06, 16'hFFFF, 16'h0004, 32'hFFFBFFFF, 16'hFFFF},
      {8'h06, 16'h7FFF, 16'h7FFF, 32'h3FFB0000, 16'h0000},
      {8'h00, 16'h0003, 16'h0005, 32'h0000000F, 16'h0000}
   };

   task automatic wr(input logic [15:0] a, input logic [15:0] d, input logic [1:0] be = 2'b11);
      @(negedge clk);
      bus_sel   = 1'b1;
      bus_wr    = 1'b1;
      bus_addr  = a;
      bus_wdata = d;
      bus_be    = be;
   endtask

   task automatic rd(input logic [15:0] a, input logic [15:0] exp, input string tag);
      @(negedge clk);
      bus_sel  = 1'b1;
      bus_wr   = 1'b0;
      bus_addr = a;
      bus_be   = 2'b11;
      #1;
      n_chk++;
      if (bus_rdata !== exp) begin
         n_err++;
         $display("FAIL %s addr %h got %h exp %h", tag, a, bus_rdata, exp);
      end
   endtask

   task automatic idle();
      @(negedge clk);
      bus_sel = 1'b0;
      bus_wr  = 1'b0;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      n_err++;
      $display("FAIL watchdog all R got timeout exp completion");
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;

      // R11 reset state
      rd(BA + 16'h00, 16'h0000, "R11 op1");
      rd(BA + 16'h0A, 16'h0000, "R11 lo");
      rd(BA + 16'h0C, 16'h0000, "R11 hi");
      rd(BA + 16'h0E, 16'h0000, "R11 ext");
      rd(BB + 16'h24, 16'h0000, "R11 w0");
      rd(BB + 16'h2A, 16'h0000, "R11 w3");

      // R2 R3 R4 R5 vector table
      for (int i = 0; i < NVEC; i++) begin
         logic [87:0] v;
         v = VEC[i];
         wr(BA + {8'h00, v[87:80]}, v[79:64]);
         wr(BA + 16'h08, v[63:48]);
         rd(BA + 16'h0A, v[31:16], $sformatf("R3 vec%0d lo", i));
         rd(BA + 16'h0C, v[47:32], $sformatf("R4 vec%0d hi", i));
         rd(BA + 16'h0E, v[15:0],  $sformatf("R5 vec%0d ext", i));
      end

      // R1 mirror windows
      wr(BB + 16'h00, 16'h0002);
      wr(BB + 16'h08, 16'h0003);
      rd(BA + 16'h0A, 16'h0006, "R1 lo via A");
      rd(BB + 16'h0A, 16'h0006, "R1 lo via B");
      rd(BA + 16'h00, 16'h0002, "R2 op1 at 0x0");
      rd(BB + 16'h02, 16'h0002, "R2 op1 at 0x2");
      rd(BA + 16'h0C, 16'h0000, "R3 hi");

      // R6 preset of low word
      wr(BA + 16'h00, 16'h0100);
      wr(BA + 16'h08, 16'h0100);
      rd(BA + 16'h0C, 16'h0001, "R3 hi 0x10000");
      rd(BA + 16'h0A, 16'h0000, "R3 lo 0x10000");
      wr(BA + 16'h0A, 16'h1234);
      rd(BA + 16'h0A, 16'h1234, "R6 preset lo");
      rd(BA + 16'h0C, 16'h0001, "R6 hi kept");
      wr(BA + 16'h0C, 16'h5555);
      rd(BA + 16'h0C, 16'h0001, "R6 hi write ignored");
      rd(BA + 16'h0C, 16'h0001, "R12 repeated read");
      wr(BA + 16'h0E, 16'h7777);
      rd(BA + 16'h0E, 16'h0000, "R6 ext write ignored");

      // R4 accumulate onto preset
      wr(BA + 16'h04, 16'h0001);
      wr(BA + 16'h08, 16'h0001);
      rd(BA + 16'h0A, 16'h1235, "R4 preset acc lo");
      rd(BA + 16'h0C, 16'h0001, "R4 preset acc hi");

      // R10 byte enables
      wr(BA + 16'h00, 16'hAAAA);
      wr(BA + 16'h00, 16'h1234, 2'b01);
      rd(BA + 16'h00, 16'hAA34, "R10 low byte only");
      wr(BA + 16'h08, 16'h0200, 2'b10);
      rd(BA + 16'h08, 16'h0201, "R10 op2 merged");
      rd(BA + 16'h0A, 16'h1234, "R10 merged product lo");
      rd(BA + 16'h0C, 16'h0155, "R10 merged product hi");
      wr(BA + 16'h00, 16'hFFFF, 2'b00);
      rd(BA + 16'h00, 16'hAA34, "R10 no byte enabled");

      // R7 R8 wide path
      wr(BB + 16'h10, 16'h5678);
      wr(BB + 16'h12, 16'h1234);
      rd(BA + 16'h10, 16'h5678, "R7 low kept");
      rd(BA + 16'h12, 16'h1234, "R7 high");
      wr(BA + 16'h20, 16'h0002);
      wr(BA + 16'h22, 16'h0000);
      rd(BA + 16'h24, 16'hACF0, "R8 u w0");
      rd(BA + 16'h26, 16'h2468, "R8 u w1");
      rd(BA + 16'h28, 16'h0000, "R8 u w2");
      rd(BA + 16'h2A, 16'h0000, "R8 u w3");

      wr(BA + 16'h14, 16'hFFFF);
      wr(BA + 16'h16, 16'hFFFF);
      wr(BA + 16'h20, 16'h0003);
      wr(BA + 16'h22, 16'h0000);
      rd(BB + 16'h24, 16'hFFFD, "R8 s w0");
      rd(BB + 16'h26, 16'hFFFF, "R8 s w1");
      rd(BB + 16'h28, 16'hFFFF, "R8 s w2");
      rd(BB + 16'h2A, 16'hFFFF, "R8 s w3");

      wr(BA + 16'h10, 16'hFFFF);
      wr(BA + 16'h16, 16'hFFFF);
      wr(BA + 16'h20, 16'h0003);
      wr(BA + 16'h22, 16'h0000);
      rd(BA + 16'h24, 16'hFFFD, "R7 mode kept w0");
      rd(BA + 16'h28, 16'h0002, "R7 mode kept w2");
      rd(BA + 16'h2A, 16'h0000, "R7 mode kept w3");

      wr(BA + 16'h10, 16'h0001);
      rd(BA + 16'h12, 16'h0000, "R7 upper cleared");
      wr(BA + 16'h22, 16'h0001);
      wr(BA + 16'h20, 16'h0003);
      rd(BA + 16'h22, 16'h0000, "R8 upper cleared");

      wr(BA + 16'h14, 16'h0000);
      wr(BA + 16'h16, 16'h8000);
      wr(BA + 16'h20, 16'hFFFF);
      wr(BA + 16'h22, 16'h7FFF);
      rd(BA + 16'h24, 16'h0000, "R8 big w0");
      rd(BA + 16'h26, 16'h8000, "R8 big w1");
      rd(BA + 16'h28, 16'h0000, "R8 big w2");
      rd(BA + 16'h2A, 16'hC000, "R8 big w3");

      // R9 gaps and outside
      wr(BA + 16'h18, 16'h1111);
      rd(BA + 16'h18, 16'h0000, "R9 gap");
      rd(BB + 16'h1E, 16'h0000, "R9 gap B");
      rd(BB + 16'h2A, 16'hC000, "R9 last word intact");
      rd(BA + 16'h2C, 16'h0000, "R9 past end A");
      rd(BA - 16'h0001, 16'h0000, "R9 below A");
      rd(BB - 16'h0002, 16'h0000, "R9 below B");
      rd(BB + 16'h2C, 16'h0000, "R9 past end B");
      wr(BA + 16'h2C, 16'h9999);
      wr(BA - 16'h0002, 16'h9999);
      rd(BA + 16'h0A, 16'h1234, "R9 lo unchanged");
      rd(BA + 16'h00, 16'hAA34, "R9 op1 unchanged");

      idle();
      idle();
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
   end

endmodule